// File: doc/BRIEF.md
# Display Link Training Sequencer

This block trains a serial display link of one, two or four lanes in two phases. The first phase is clock recovery and the second is channel equalization. The host loads a lane count and pulses `start`. The sequencer then talks to the sink's configuration space through a single-request AUX port, where each request is either a write of up to four bytes or a read of up to six. It also drives the transmitter's training pattern select and one drive-setting byte per lane. The transport behind the AUX port and the analog behaviour of the transmitter are outside the block.

In every round the sequencer waits a programmable number of cycles and then reads the sink's six-byte lane status block. It decodes the lane flags from that block. If a phase is not finished, it builds one new drive setting from the sink's per-lane adjust requests. The new setting takes the largest requested swing and the largest requested pre-emphasis over the active lanes, and it is applied to every lane alike.

The run ends with `done`, or with `fail` and a reason code. Both stay valid until the next start.

Top module: `link_trainer`

## Requirements
- R1: After reset, `done`, `fail`, `fail_code`, `tx_pattern`, `lane_drive` and `aux_req` are all zero.
- R2: On `start`, the lane count is latched and all drive settings are zeroed. `tx_pattern` becomes 1, and the first request writes byte 0x01, length 1, to sink address 0x00102.
- R3: Each clock recovery round does three things in order:
  - It writes the drive bytes to address 0x00103, with length equal to the lane count and the same byte in every byte of `aux_wdata`.
  - It waits at least `CR_WAIT_CYC` cycles after that write completes.
  - It reads six bytes from address 0x00202.
- R4: The status layout is as follows:
  - Byte 0 holds lanes 0 and 1, and byte 1 holds lanes 2 and 3. The odd lane uses the upper nibble of its byte.
  - In each nibble, bit 0 means clock recovered, bit 1 means equalized and bit 2 means symbol locked.
  - Clock recovery passes when bit 0 is set for every active lane, where the active lanes are those below the lane count. The flags of inactive lanes are ignored.
- R5: The adjust requests are in byte 4 (lanes 0 and 1) and byte 5 (lanes 2 and 3):
  - For an even lane, swing is in bits [1:0] and pre-emphasis in bits [3:2]. For an odd lane, swing is in bits [5:4] and pre-emphasis in bits [7:6].
  - The new drive byte takes the maximum of each field over the active lanes only. Its layout is swing in bits [1:0], a swing-at-maximum flag in bit 2, pre-emphasis in bits [4:3] and a pre-emphasis-at-maximum flag in bit 5. Each flag is set when its level is 3.
  - All four bytes of `lane_drive` carry this value.
- R6: If clock recovery has not passed and the current drive already has the swing-at-maximum flag, the run fails with code 2.
- R7: A stall counter works in the rounds where clock recovery has not passed:
  - It increments when the lane-0 swing equals the swing of the previous round, and it clears when the swing differs.
  - When it reaches `STALL_LIMIT`, the run fails with code 1. With the default of 5, a sink that always requests swing 1 causes failure at the 7th status read.
- R8: Equalization works as follows:
  - It sets `tx_pattern` to 2 and writes 0x02 to address 0x00102.
  - Each round waits at least `EQ_WAIT_CYC` cycles and then reads the status. New drive settings are applied locally only.
  - After `EQ_TRIES` failing reads, the run fails with code 3.
- R9: Equalization passes when bit 0 of status byte 2 is set and nibble bits [2:0] are all set on every active lane.
- R10: On success, `tx_pattern` returns to 0 and 0x00 is written to address 0x00102. `done` rises in the cycle after that write completes.
- R11: A completed request with `aux_err` high ends the run with code 0. After any failure, `tx_pattern` is 0.
- R12: `done` and `fail` are never high together. They hold their value until the next `start`, and a new run can begin after either outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (accepted when idle) |
| lane_count | input | 3 | Lanes to train: 1, 2 or 4 |
| aux_req | output | 1 | Request pending; fields stay stable until acknowledged |
| aux_write | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 20 | Sink register address |
| aux_len | output | 3 | Byte count of the request |
| aux_wdata | output | 32 | Write bytes, byte 0 in bits [7:0] |
| aux_ack | input | 1 | Request completed this cycle |
| aux_err | input | 1 | Completed request failed (valid with `aux_ack`) |
| aux_rdata | input | 48 | Read bytes, byte 0 in bits [7:0] (valid with `aux_ack`) |
| lane_drive | output | 32 | Drive byte per lane, lane 0 in bits [7:0] |
| tx_pattern | output | 2 | Local pattern: 0 off, 1 clock recovery, 2 equalization |
| done | output | 1 | Training succeeded |
| fail | output | 1 | Training failed |
| fail_code | output | 2 | 0 AUX error, 1 swing stall, 2 maximum swing, 3 equalization timeout |

## Verification
The hardest case to reach from the ports is the swing stall abort. It needs a sink that keeps clock recovery unfinished for seven rounds while asking for the same swing every time, and never for the maximum swing. Reaching it also depends on the round where the stall count does not advance, because no previous swing exists yet. The bench acts as a scripted sink: for each run, a driver queues every expected request together with the reply to give. The stall run queues seven identical failing status blocks, and each lane-set write checks the drive value the sequencer derived from them. Inactive lanes are fed contradictory flags and adjust requests to show that they are ignored.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;
    localparam int LANES      = 4;
    localparam int STAT_BYTES = 6;
    localparam int STAT_W     = 8 * STAT_BYTES;
    localparam int ADDR_W     = 20;
    localparam int LEN_W      = 3;
    localparam int WDATA_W    = 8 * LANES;
    localparam int LCNT_W     = 3;

    localparam logic [ADDR_W-1:0] ADDR_PATTERN  = 20'h00102;
    localparam logic [ADDR_W-1:0] ADDR_LANE_SET = 20'h00103;
    localparam logic [ADDR_W-1:0] ADDR_STATUS   = 20'h00202;
    localparam int ADJ_BYTE   = 4;
    localparam int ALIGN_BYTE = 2;
    localparam logic [1:0] LVL_MAX = 2'd3;

    typedef enum logic [1:0] {
        PAT_OFF = 2'd0,
        PAT_CR  = 2'd1,
        PAT_EQ  = 2'd2
    } pattern_e;

    typedef enum logic [1:0] {
        FC_AUX      = 2'd0,
        FC_STALL    = 2'd1,
        FC_MAXSWING = 2'd2,
        FC_EQ       = 2'd3
    } fail_e;

    typedef struct packed {
        logic       max_pre;
        logic [1:0] pre;
        logic       max_swing;
        logic [1:0] swing;
    } drive_t;

    typedef enum logic [3:0] {
        S_IDLE, S_CR_PAT, S_CR_SET, S_CR_WAIT, S_CR_READ, S_CR_EVAL,
        S_EQ_PAT, S_EQ_WAIT, S_EQ_READ, S_EQ_EVAL, S_OFF
    } state_e;

    // Low three flag bits of one lane's status nibble.
    function automatic logic [2:0] lane_flags(logic [STAT_W-1:0] st, int lane);
        return st[8*(lane >> 1) + 4*(lane & 1) +: 3];
    endfunction

    function automatic logic [7:0] adj_byte(logic [STAT_W-1:0] st, int lane);
        return st[8*(ADJ_BYTE + (lane >> 1)) +: 8];
    endfunction

    function automatic logic [1:0] req_swing(logic [STAT_W-1:0] st, int lane);
        logic [7:0] b;
        b = adj_byte(st, lane);
        return (lane & 1) != 0 ? b[5:4] : b[1:0];
    endfunction

    function automatic logic [1:0] req_pre(logic [STAT_W-1:0] st, int lane);
        logic [7:0] b;
        b = adj_byte(st, lane);
        return (lane & 1) != 0 ? b[7:6] : b[3:2];
    endfunction

    function automatic logic [7:0] drive_byte(drive_t d);
        return {2'b00, d};
    endfunction

    // Normalised active lane count: 4, 2 or 1.
    function automatic logic [LCNT_W-1:0] norm_count(logic [LCNT_W-1:0] c);
        if (c >= 3'd4)      return 3'd4;
        else if (c >= 3'd2) return 3'd2;
        else                return 3'd1;
    endfunction

    function automatic logic [LANES-1:0] mask_of(logic [LCNT_W-1:0] c);
        logic [LANES-1:0] m;
        for (int i = 0; i < LANES; i++) m[i] = (i < int'(c));
        return m;
    endfunction
endpackage

// File: rtl/lt_wait_timer.sv
`timescale 1ns/1ps
module lt_wait_timer #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (load) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (running && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = running && (cnt == '0);
endmodule

// File: rtl/lt_status_decode.sv
`timescale 1ns/1ps
module lt_status_decode
    import lt_pkg::*;
(
    input  logic [STAT_W-1:0] status,
    input  logic [LANES-1:0]  lane_mask,
    output logic              cr_ok,
    output logic              eq_ok,
    output drive_t            next_drive
);
    logic [LANES-1:0] cr_hit;
    logic [LANES-1:0] eq_hit;
    logic [1:0]       sw_req [LANES];
    logic [1:0]       pr_req [LANES];
    logic [1:0]       sw_max;
    logic [1:0]       pr_max;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [2:0] flags;
        assign flags     = lane_flags(status, g);
        assign cr_hit[g] = ~lane_mask[g] | flags[0];
        assign eq_hit[g] = ~lane_mask[g] | (&flags);
        assign sw_req[g] = lane_mask[g] ? req_swing(status, g) : 2'd0;
        assign pr_req[g] = lane_mask[g] ? req_pre(status, g)   : 2'd0;
    end

    always_comb begin
        sw_max = 2'd0;
        pr_max = 2'd0;
        for (int i = 0; i < LANES; i++) begin
            if (sw_req[i] > sw_max) sw_max = sw_req[i];
            if (pr_req[i] > pr_max) pr_max = pr_req[i];
        end
    end

    assign cr_ok = &cr_hit;
    assign eq_ok = status[8*ALIGN_BYTE] & (&eq_hit);

    assign next_drive.swing     = sw_max;
    assign next_drive.max_swing = (sw_max == LVL_MAX);
    assign next_drive.pre       = pr_max;
    assign next_drive.max_pre   = (pr_max == LVL_MAX);

    logic unused_status_bits;
    assign unused_status_bits = ^{status[31:17], status[15], status[11],
                                  status[7], status[3]};
endmodule

// File: rtl/link_trainer.sv
`timescale 1ns/1ps
module link_trainer
    import lt_pkg::*;
#(
    parameter int CR_WAIT_CYC = 200000,
    parameter int EQ_WAIT_CYC = 80000,
    parameter int STALL_LIMIT = 5,
    parameter int EQ_TRIES    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          lane_count,
    output logic                aux_req,
    output logic                aux_write,
    output logic [19:0]         aux_addr,
    output logic [2:0]          aux_len,
    output logic [31:0]         aux_wdata,
    input  logic                aux_ack,
    input  logic                aux_err,
    input  logic [47:0]         aux_rdata,
    output logic [31:0]         lane_drive,
    output logic [1:0]          tx_pattern,
    output logic                done,
    output logic                fail,
    output logic [1:0]          fail_code
);
    localparam int WAIT_MAX = (CR_WAIT_CYC > EQ_WAIT_CYC) ? CR_WAIT_CYC : EQ_WAIT_CYC;
    localparam int TMR_W    = $clog2(WAIT_MAX + 1);
    localparam int STALL_W  = $clog2(STALL_LIMIT + 1);
    localparam int EQC_W    = $clog2(EQ_TRIES + 1);

    state_e              state;
    drive_t              drive;
    logic [LCNT_W-1:0]   act_cnt;
    logic [STAT_W-1:0]   status_q;
    logic [STALL_W-1:0]  stall_cnt;
    logic [1:0]          prev_swing;
    logic                prev_valid;
    logic [EQC_W-1:0]    eq_cnt;

    logic                cr_ok;
    logic                eq_ok;
    drive_t              adj_drive;
    logic                tmr_load;
    logic [TMR_W-1:0]    tmr_val;
    logic                tmr_done;
    logic                ack_ok;

    lt_status_decode u_decode (
        .status     (status_q),
        .lane_mask  (mask_of(act_cnt)),
        .cr_ok      (cr_ok),
        .eq_ok      (eq_ok),
        .next_drive (adj_drive)
    );

    lt_wait_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign ack_ok = aux_ack && !aux_err;

    // Timer restarts after the lane-set write, the pattern-2 write, and a
    // failing equalization round that will retry.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(EQ_WAIT_CYC - 1);
        case (state)
            S_CR_SET: begin
                tmr_load = ack_ok;
                tmr_val  = TMR_W'(CR_WAIT_CYC - 1);
            end
            S_EQ_PAT:  tmr_load = ack_ok;
            S_EQ_EVAL: tmr_load = !eq_ok && (eq_cnt != EQC_W'(EQ_TRIES - 1));
            default: ;
        endcase
    end

    // Request fields come straight from the state, so they stay stable
    // until the acknowledge moves the state on.
    always_comb begin
        aux_req   = 1'b0;
        aux_write = 1'b0;
        aux_addr  = '0;
        aux_len   = '0;
        aux_wdata = '0;
        case (state)
            S_CR_PAT, S_EQ_PAT, S_OFF: begin
                aux_req   = 1'b1;
                aux_write = 1'b1;
                aux_addr  = ADDR_PATTERN;
                aux_len   = 3'd1;
                aux_wdata = {24'd0, 6'd0,
                             (state == S_CR_PAT) ? PAT_CR :
                             (state == S_EQ_PAT) ? PAT_EQ : PAT_OFF};
            end
            S_CR_SET: begin
                aux_req   = 1'b1;
                aux_write = 1'b1;
                aux_addr  = ADDR_LANE_SET;
                aux_len   = act_cnt;
                aux_wdata = {LANES{drive_byte(drive)}};
            end
            S_CR_READ, S_EQ_READ: begin
                aux_req  = 1'b1;
                aux_addr = ADDR_STATUS;
                aux_len  = 3'(STAT_BYTES);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            drive      <= '0;
            act_cnt    <= 3'd1;
            status_q   <= '0;
            stall_cnt  <= '0;
            prev_swing <= '0;
            prev_valid <= 1'b0;
            eq_cnt     <= '0;
            tx_pattern <= PAT_OFF;
            done       <= 1'b0;
            fail       <= 1'b0;
            fail_code  <= FC_AUX;
        end else begin
            if (aux_req && aux_ack && aux_err) begin
                fail       <= 1'b1;
                fail_code  <= FC_AUX;
                tx_pattern <= PAT_OFF;
                state      <= S_IDLE;
            end else begin
                case (state)
                    S_IDLE: if (start) begin
                        done       <= 1'b0;
                        fail       <= 1'b0;
                        fail_code  <= FC_AUX;
                        act_cnt    <= norm_count(lane_count);
                        drive      <= '0;
                        stall_cnt  <= '0;
                        prev_valid <= 1'b0;
                        eq_cnt     <= '0;
                        tx_pattern <= PAT_CR;
                        state      <= S_CR_PAT;
                    end
                    S_CR_PAT:  if (aux_ack) state <= S_CR_SET;
                    S_CR_SET:  if (aux_ack) state <= S_CR_WAIT;
                    S_CR_WAIT: if (tmr_done) state <= S_CR_READ;
                    S_CR_READ: if (aux_ack) begin
                        status_q <= aux_rdata;
                        state    <= S_CR_EVAL;
                    end
                    S_CR_EVAL: begin
                        if (cr_ok) begin
                            tx_pattern <= PAT_EQ;
                            state      <= S_EQ_PAT;
                        end else if (drive.max_swing) begin
                            fail       <= 1'b1;
                            fail_code  <= FC_MAXSWING;
                            tx_pattern <= PAT_OFF;
                            state      <= S_IDLE;
                        end else if (prev_valid && drive.swing == prev_swing &&
                                     stall_cnt == STALL_W'(STALL_LIMIT - 1)) begin
                            fail       <= 1'b1;
                            fail_code  <= FC_STALL;
                            tx_pattern <= PAT_OFF;
                            state      <= S_IDLE;
                        end else begin
                            if (prev_valid && drive.swing == prev_swing)
                                stall_cnt <= stall_cnt + 1'b1;
                            else
                                stall_cnt <= '0;
                            prev_swing <= drive.swing;
                            prev_valid <= 1'b1;
                            drive      <= adj_drive;
                            state      <= S_CR_SET;
                        end
                    end
                    S_EQ_PAT:  if (aux_ack) state <= S_EQ_WAIT;
                    S_EQ_WAIT: if (tmr_done) state <= S_EQ_READ;
                    S_EQ_READ: if (aux_ack) begin
                        status_q <= aux_rdata;
                        state    <= S_EQ_EVAL;
                    end
                    S_EQ_EVAL: begin
                        if (eq_ok) begin
                            tx_pattern <= PAT_OFF;
                            state      <= S_OFF;
                        end else if (eq_cnt == EQC_W'(EQ_TRIES - 1)) begin
                            fail       <= 1'b1;
                            fail_code  <= FC_EQ;
                            tx_pattern <= PAT_OFF;
                            state      <= S_IDLE;
                        end else begin
                            eq_cnt <= eq_cnt + 1'b1;
                            drive  <= adj_drive;
                            state  <= S_EQ_WAIT;
                        end
                    end
                    S_OFF: if (aux_ack) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign lane_drive = {LANES{drive_byte(drive)}};
endmodule

// File: rtl/link_trainer_chk.sv
`timescale 1ns/1ps
module link_trainer_chk (
    input logic        clk,
    input logic        rst,
    input logic        aux_req,
    input logic        aux_write,
    input logic [19:0] aux_addr,
    input logic [2:0]  aux_len,
    input logic [31:0] aux_wdata,
    input logic        aux_ack,
    input logic [7:0]  drive0,
    input logic [1:0]  tx_pattern,
    input logic        done,
    input logic        fail
);
    // R12
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && fail));

    // R3
    aux_hold_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && !aux_ack |=> aux_req && $stable(aux_addr) && $stable(aux_wdata)
                                && $stable(aux_len) && $stable(aux_write));

    // R5
    max_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (drive0[2] == (drive0[1:0] == 2'd3)) && (drive0[5] == (drive0[4:3] == 2'd3)));

    // R10
    done_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> tx_pattern == 2'd0 && $past(aux_ack));

    // R11
    fail_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> tx_pattern == 2'd0);

    // R8
    lane_set_phase_chk: assert property (@(posedge clk) disable iff (rst)
        aux_req && aux_write && aux_addr == 20'h00103 |-> tx_pattern == 2'd1);

    // R2
    pattern_legal_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pattern != 2'd3);
endmodule

bind link_trainer link_trainer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .aux_req    (aux_req),
    .aux_write  (aux_write),
    .aux_addr   (aux_addr),
    .aux_len    (aux_len),
    .aux_wdata  (aux_wdata),
    .aux_ack    (aux_ack),
    .drive0     (lane_drive[7:0]),
    .tx_pattern (tx_pattern),
    .done       (done),
    .fail       (fail)
);

// File: tb/tb_link_trainer.sv
`timescale 1ns/1ps
module tb_link_trainer;
    localparam int CRW = 20;
    localparam int EQW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  lane_count = 3'd4;
    logic        aux_req, aux_write;
    logic [19:0] aux_addr;
    logic [2:0]  aux_len;
    logic [31:0] aux_wdata;
    logic        aux_ack = 1'b0;
    logic        aux_err = 1'b0;
    logic [47:0] aux_rdata = '0;
    logic [31:0] lane_drive;
    logic [1:0]  tx_pattern;
    logic        done, fail;
    logic [1:0]  fail_code;

    always #2.5 clk = ~clk;

    link_trainer #(.CR_WAIT_CYC(CRW), .EQ_WAIT_CYC(EQW)) dut (
        .clk(clk), .rst(rst), .start(start), .lane_count(lane_count),
        .aux_req(aux_req), .aux_write(aux_write), .aux_addr(aux_addr),
        .aux_len(aux_len), .aux_wdata(aux_wdata), .aux_ack(aux_ack),
        .aux_err(aux_err), .aux_rdata(aux_rdata), .lane_drive(lane_drive),
        .tx_pattern(tx_pattern), .done(done), .fail(fail), .fail_code(fail_code)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_ack = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic        wr;
        logic [19:0] addr;
        logic [2:0]  len;
        logic [31:0] wdata;
        logic [1:0]  pat;
        int          min_wait;
        logic        err;
        logic [47:0] rdata;
        string       tag;
    } item_t;
    item_t q[$];

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Status block: nib = 4 lane nibbles (lane 0 low), sw/pr = 2 bits per lane.
    function automatic logic [47:0] mkst(logic [15:0] nib, logic align,
                                         logic [7:0] sw, logic [7:0] pr);
        logic [7:0] b4, b5;
        b4 = {pr[3:2], sw[3:2], pr[1:0], sw[1:0]};
        b5 = {pr[7:6], sw[7:6], pr[5:4], sw[5:4]};
        return {b5, b4, 8'h00, 7'd0, align, nib};
    endfunction

    // Driver side: expected requests and the replies to give.
    task automatic exp_wr(logic [19:0] a, logic [2:0] n, logic [31:0] d,
                          logic [1:0] p, string tag, logic e = 1'b0);
        item_t it;
        it.wr = 1'b1; it.addr = a; it.len = n; it.wdata = d; it.pat = p;
        it.min_wait = 0; it.err = e; it.rdata = '0; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic exp_rd(logic [47:0] st, logic [1:0] p, int mw, string tag);
        item_t it;
        it.wr = 1'b0; it.addr = 20'h00202; it.len = 3'd6; it.wdata = '0; it.pat = p;
        it.min_wait = mw; it.err = 1'b0; it.rdata = st; it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor side: the scripted sink.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && aux_req && !aux_ack) begin
                item_t it;
                if (q.size() == 0) begin
                    check(1'b0, "R12", "unexpected request", {43'd0, aux_addr, aux_write}, 64'd0);
                    it.err = 1'b0; it.rdata = '0;
                end else begin
                    it = q.pop_front();
                    check({aux_write, aux_addr, aux_len, aux_wdata, tx_pattern} ==
                          {it.wr, it.addr, it.len, it.wdata, it.pat}, it.tag, "request",
                          {6'd0, aux_write, aux_addr, aux_len, aux_wdata, tx_pattern},
                          {6'd0, it.wr, it.addr, it.len, it.wdata, it.pat});
                    check(!done && !fail, "R12", "idle flags while busy",
                          {62'd0, done, fail}, 64'd0);
                    if (it.min_wait > 0)
                        check(cyc - last_ack >= it.min_wait, it.tag, "wait before read",
                              64'(cyc - last_ack), 64'(it.min_wait));
                end
                repeat (2) @(negedge clk);
                aux_rdata = it.rdata;
                aux_err   = it.err;
                aux_ack   = 1'b1;
                last_ack  = cyc;
                @(negedge clk);
                aux_ack = 1'b0;
                aux_err = 1'b0;
            end
        end
    end

    task automatic kick(logic [2:0] lc);
        @(negedge clk);
        lane_count = lc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_case(logic exp_done, logic [1:0] code, logic [31:0] drv, string tag);
        int n = 0;
        while (!(done || fail) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        check(q.size() == 0, tag, "requests left", 64'(q.size()), 64'd0);
        check({done, fail, fail_code, tx_pattern, lane_drive} ==
              {exp_done, !exp_done, code, 2'd0, drv}, tag, "outcome",
              {26'd0, done, fail, fail_code, tx_pattern, lane_drive},
              {26'd0, exp_done, !exp_done, code, 2'd0, drv});
        repeat (3) @(negedge clk);
        check(done == exp_done && fail == !exp_done, "R12", "outcome held",
              {62'd0, done, fail}, {62'd0, exp_done, !exp_done});
        q.delete();
    endtask

    localparam logic [19:0] A_PAT = 20'h00102;
    localparam logic [19:0] A_SET = 20'h00103;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check({done, fail, fail_code, tx_pattern, lane_drive, aux_req} == '0, "R1",
              "reset state", {27'd0, done, fail, fail_code, tx_pattern, lane_drive, aux_req}, 64'd0);

        // R2 R3 R9 R10: four lanes, both phases pass at once
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R2");
        exp_wr(A_SET, 3'd4, 32'h0, 2'd1, "R3");
        exp_rd(mkst(16'h1111, 1'b0, 8'h00, 8'h00), 2'd1, CRW, "R3");
        exp_wr(A_PAT, 3'd1, 32'h02, 2'd2, "R8");
        exp_rd(mkst(16'h7777, 1'b1, 8'h00, 8'h00), 2'd2, EQW, "R9");
        exp_wr(A_PAT, 3'd1, 32'h00, 2'd0, "R10");
        kick(3'd4);
        finish_case(1'b1, 2'd0, 32'h0, "R10");

        // R4 R5 R8: two lanes, inactive lanes carry conflicting flags and requests
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R2");
        exp_wr(A_SET, 3'd2, 32'h0, 2'd1, "R3");
        exp_rd(mkst(16'h0010, 1'b0, 8'b11_00_10_01, 8'b11_00_01_00), 2'd1, CRW, "R5");
        exp_wr(A_SET, 3'd2, 32'h0A0A0A0A, 2'd1, "R5");
        exp_rd(mkst(16'h0011, 1'b0, 8'h00, 8'h00), 2'd1, CRW, "R4");
        exp_wr(A_PAT, 3'd1, 32'h02, 2'd2, "R8");
        exp_rd(mkst(16'h0037, 1'b1, 8'b00_00_00_11, 8'b00_00_11_00), 2'd2, EQW, "R9");
        exp_rd(mkst(16'h0077, 1'b1, 8'h00, 8'h00), 2'd2, EQW, "R9");
        exp_wr(A_PAT, 3'd1, 32'h00, 2'd0, "R10");
        kick(3'd2);
        finish_case(1'b1, 2'd0, 32'h3F3F3F3F, "R5");

        // R6: one lane, swing rises to the maximum, then abort
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R2");
        exp_wr(A_SET, 3'd1, 32'h0, 2'd1, "R3");
        exp_rd(mkst(16'h1110, 1'b0, 8'h03, 8'h00), 2'd1, CRW, "R6");
        exp_wr(A_SET, 3'd1, 32'h07070707, 2'd1, "R5");
        exp_rd(mkst(16'h1110, 1'b0, 8'h03, 8'h00), 2'd1, CRW, "R6");
        kick(3'd1);
        finish_case(1'b0, 2'd2, 32'h07070707, "R6");

        // R7: swing stuck at 1, abort at the 7th status read
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R2");
        for (int k = 0; k < 7; k++) begin
            exp_wr(A_SET, 3'd1, (k == 0) ? 32'h0 : 32'h01010101, 2'd1, "R7");
            exp_rd(mkst(16'h0000, 1'b0, 8'h01, 8'h00), 2'd1, CRW, "R7");
        end
        kick(3'd1);
        finish_case(1'b0, 2'd1, 32'h01010101, "R7");

        // R8: equalization never aligns, five tries
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R2");
        exp_wr(A_SET, 3'd4, 32'h0, 2'd1, "R3");
        exp_rd(mkst(16'h1111, 1'b0, 8'h00, 8'h00), 2'd1, CRW, "R4");
        exp_wr(A_PAT, 3'd1, 32'h02, 2'd2, "R8");
        for (int k = 0; k < 5; k++)
            exp_rd(mkst(16'h7777, 1'b0, 8'h00, 8'h00), 2'd2, EQW, "R8");
        kick(3'd4);
        finish_case(1'b0, 2'd3, 32'h0, "R8");

        // R11: AUX error on the first request
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R11", 1'b1);
        kick(3'd4);
        finish_case(1'b0, 2'd0, 32'h0, "R11");

        // R12: a new run after a failure succeeds
        exp_wr(A_PAT, 3'd1, 32'h01, 2'd1, "R12");
        exp_wr(A_SET, 3'd4, 32'h0, 2'd1, "R12");
        exp_rd(mkst(16'h1111, 1'b0, 8'h00, 8'h00), 2'd1, CRW, "R12");
        exp_wr(A_PAT, 3'd1, 32'h02, 2'd2, "R12");
        exp_rd(mkst(16'h7777, 1'b1, 8'h00, 8'h00), 2'd2, EQW, "R12");
        exp_wr(A_PAT, 3'd1, 32'h00, 2'd0, "R12");
        kick(3'd4);
        finish_case(1'b1, 2'd0, 32'h0, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL R12 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule